// File: doc/BRIEF.md
# Peripheral Bus Address Decoder

This block sits between a CPU's 24-bit address bus and an on-chip peripheral bus. For each access request it decides whether the address belongs to one of two on-chip RAM regions or to one of six 256-byte peripheral windows. It then drives a single select for that target, together with the byte offset inside the target. An address that hits no enabled target is handed to the external bus through a one-cycle pass pulse.

A peripheral window is live only when two things are both set: the global peripheral-bus enable and that window's own bit in the peripheral enable vector. Window accesses carry a fixed number of wait states before ready, and they accept 16-bit word accesses only. A byte access to a live window is refused with a one-cycle error pulse and then completes. RAM accesses of either size complete with no wait state. The larger RAM repeats every 16 KB across its 64 KB segment. A registered flag tells the port logic to cap the external segment address lines at four whenever a CAN window is live.

Requests are single-cycle pulses. A new request is taken only while the block is idle.

Top module: `pbus_decode`

## Requirements
- R1: The small RAM (select `ram_sel[0]`) is hit for addresses 0x00E000 to 0x00E7FF only while `ram_lo_en` is 1, with `dev_off` = address minus 0x00E000. With `ram_lo_en` at 0, such an address goes to the external bus.
- R2: Any address with bits [23:16] = 0x09 hits the large RAM (select `ram_sel[1]`) with `dev_off` = address bits [13:0], so 0x090000, 0x094000 and 0x09C000 alias the same word.
- R3: Window pages map to `win_sel` bits as follows: 0x00EF00 to bit 0 (CAN A), 0x00EE00 to bit 1 (CAN B), 0x00ED00 to bit 2 (RTC), 0x00EC00 to bit 3 (PWM), 0x00E900 to bit 4 (UART) and 0x00E800 to bit 5 (SPI). Each window spans 256 bytes, and `dev_off` = address bits [7:0].
- R4: A window is hit only when `bus_en` is 1 and its bit in `per_en` is 1. The `per_en` bits are 0, 1, 4, 6, 7 and 8 for `win_sel` bits 0 to 5; the other `per_en` bits have no effect. Otherwise the access goes to the external bus.
- R5: At most one of `ram_sel`, `win_sel` and `ext_sel` is high in any cycle.
- R6: A RAM hit, word or byte, drives its select and `rdy` together for exactly the one cycle after the request edge.
- R7: A word access to a live window holds its select for WAIT_N+1 cycles (3 by default), starting the cycle after the request edge. `rdy` is high only in the last of them.
- R8: A byte access to a live window drives no select. It raises `acc_err` for one cycle after the request edge, and `rdy` follows in the next cycle.
- R9: An access that hits nothing raises `ext_sel` for the one cycle after the request edge, with no select and no `rdy`.
- R10: A request that arrives before the current access has completed is ignored and produces no response.
- R11: `seg_cap` is 1 one cycle after `bus_en` is 1 together with `per_en[0]` or `per_en[1]`, and 0 otherwise.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request pulse |
| addr | input | 24 | Byte address of the access |
| byte_acc | input | 1 | 1 for a byte access, 0 for a word access |
| bus_en | input | 1 | Global peripheral-bus enable |
| per_en | input | 9 | Per-window enable vector |
| ram_lo_en | input | 1 | Enable for the small RAM region |
| ram_sel | output | 2 | Bit 0 selects the small RAM, bit 1 the large RAM |
| win_sel | output | 6 | One select per peripheral window |
| ext_sel | output | 1 | Access passed to the external bus |
| dev_off | output | 14 | Byte offset inside the selected target |
| rdy | output | 1 | Access complete |
| acc_err | output | 1 | Refused byte access to a window |
| seg_cap | output | 1 | Limit external segment lines to four |

## Verification
The bound checker watches every cycle for the properties that do not depend on the address. Selects and the pass pulse must be mutually exclusive. Each window access must hold its select for exactly the wait-state count before ready. A RAM select may appear only in a ready cycle. The error and pass pulses must last one cycle, the error pulse must lead ready, and the segment-cap flag must follow the global enable.

Which target a given address reaches can only be shown by the bench's scenarios. Those scenarios cover window and RAM edges, the mirror aliases of the large RAM, every combination of the global and per-window enables, byte refusals, and requests dropped while busy.

// File: rtl/pbus_pkg.sv
// Shared constants and types of the peripheral bus decoder.
// Assumes a 24-bit byte address, 256-byte windows and a 64 KB segment.
package pbus_pkg;

    localparam int ADDR_W  = 24;   // CPU byte address width
    localparam int WIN_N   = 6;    // number of peripheral windows
    localparam int WIN_AW  = 8;    // address bits inside one window
    localparam int LO_AW   = 11;   // address bits inside the small RAM
    localparam int HI_AW   = 14;   // address bits inside the large RAM
    localparam int SEG_LSB = 16;   // lowest bit of the segment number
    localparam int OFF_W   = 14;   // width of the offset output
    localparam int EN_W    = 9;    // width of the per-window enable vector
    localparam int WAIT_N  = 2;    // wait states of a window access
    localparam int TGT_W   = WIN_N + 2;  // RAMs plus windows
    localparam int PAGE_FW = 16;   // stored page field width
    localparam int ENB_FW  = 4;    // stored enable-bit index field width

    // Segment of the large RAM and base of the small RAM
    localparam logic [ADDR_W-SEG_LSB-1:0] HI_SEG  = 8'h09;
    localparam logic [ADDR_W-1:0]         LO_BASE = 24'h00E000;

    // Window pages (address bits [23:8]), window 0 in the lowest field
    localparam logic [WIN_N*PAGE_FW-1:0] WIN_PAGE =
        {16'h00E8, 16'h00E9, 16'h00EC, 16'h00ED, 16'h00EE, 16'h00EF};

    // Enable-vector bit of each window, window 0 in the lowest field
    localparam logic [WIN_N*ENB_FW-1:0] WIN_ENBIT =
        {4'd8, 4'd7, 4'd6, 4'd4, 4'd1, 4'd0};

    // Number of leading windows whose enable drives the segment cap
    localparam int CAP_WINS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DONE,
        ST_FAULT,
        ST_PASS
    } seq_state_t;

endpackage

// File: rtl/pbus_win_match.sv
// Compares the address page with every peripheral window and gates each
// hit with the global bus enable and that window's own enable bit.
// Assumes the window pages in the package do not overlap.
module pbus_win_match
    import pbus_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_WIN_N  = WIN_N,
    parameter int P_WIN_AW = WIN_AW,
    parameter int P_EN_W   = EN_W
) (
    input  logic [P_ADDR_W-1:0] addr,
    input  logic                bus_en,
    input  logic [P_EN_W-1:0]   per_en,
    output logic [P_WIN_N-1:0]  win_hit,
    output logic                win_any
);

    localparam int PAGE_W = P_ADDR_W - P_WIN_AW;

    logic [PAGE_W-1:0] page;

    assign page = addr[P_ADDR_W-1:P_WIN_AW];

    for (genvar i = 0; i < P_WIN_N; i++) begin : g_win
        localparam logic [PAGE_W-1:0] MY_PAGE =
            PAGE_W'(WIN_PAGE[i*PAGE_FW +: PAGE_FW]);
        localparam int MY_EN = int'(WIN_ENBIT[i*ENB_FW +: ENB_FW]);

        // Window i is hit when its page matches and both enables are set
        always_comb begin
            win_hit[i] = (page == MY_PAGE) && bus_en && per_en[MY_EN];
        end
    end

    // Any live window was hit
    always_comb begin
        win_any = |win_hit;
    end

endmodule

// File: rtl/pbus_ram_match.sv
// Decodes the two RAM regions. The small region needs its own enable; the
// large one aliases every 16 KB inside its segment.
// Assumes the small region is aligned to its own size.
module pbus_ram_match
    import pbus_pkg::*;
#(
    parameter int P_ADDR_W  = ADDR_W,
    parameter int P_LO_AW   = LO_AW,
    parameter int P_SEG_LSB = SEG_LSB
) (
    input  logic [P_ADDR_W-1:0] addr,
    input  logic                lo_en,
    output logic                lo_hit,
    output logic                hi_hit
);

    localparam logic [P_ADDR_W-P_LO_AW-1:0] LO_TAG =
        LO_BASE[P_ADDR_W-1:P_LO_AW];

    // Small RAM: tag compare above its size, gated by its enable
    always_comb begin
        lo_hit = lo_en && (addr[P_ADDR_W-1:P_LO_AW] == LO_TAG);
    end

    // Large RAM: only the segment number matters, lower bits alias
    always_comb begin
        hi_hit = (addr[P_ADDR_W-1:P_SEG_LSB] == HI_SEG);
    end

endmodule

// File: rtl/pbus_seq.sv
// Access sequencer: captures one request while idle, holds the target
// select through the wait states and raises ready, error or pass pulses.
// Assumes hit_vec is one-hot or zero and win_any marks a window hit.
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int P_TGT_W  = TGT_W,
    parameter int P_OFF_W  = OFF_W,
    parameter int P_WAIT_N = WAIT_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               is_byte,
    input  logic [P_TGT_W-1:0] hit_vec,
    input  logic               win_any,
    input  logic [P_OFF_W-1:0] off_in,
    output logic [P_TGT_W-1:0] tgt_q,
    output logic [P_OFF_W-1:0] off_q,
    output logic               rdy,
    output logic               flt,
    output logic               pass
);

    localparam int CNT_W = (P_WAIT_N > 1) ? $clog2(P_WAIT_N) : 1;

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             take;
    logic             refuse;

    // A request is accepted only in idle; a byte access to a window is refused
    always_comb begin
        take   = (state_q == ST_IDLE) && req;
        refuse = win_any && is_byte;
    end

    // State, wait counter, held target and offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tgt_q   <= '0;
            off_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        off_q <= off_in;
                        if ((|hit_vec) && !refuse) begin
                            tgt_q <= hit_vec;
                            if (win_any && (P_WAIT_N > 0)) begin
                                state_q <= ST_WAIT;
                                cnt_q   <= CNT_W'(P_WAIT_N - 1);
                            end else begin
                                state_q <= ST_DONE;
                            end
                        end else if (refuse) begin
                            state_q <= ST_FAULT;
                        end else begin
                            state_q <= ST_PASS;
                        end
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_DONE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                    tgt_q   <= '0;
                end
                ST_FAULT: begin
                    state_q <= ST_DONE;
                end
                ST_PASS: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                    tgt_q   <= '0;
                end
            endcase
        end
    end

    // Response pulses decoded from the registered state
    always_comb begin
        rdy  = (state_q == ST_DONE);
        flt  = (state_q == ST_FAULT);
        pass = (state_q == ST_PASS);
    end

endmodule

// File: rtl/pbus_decode.sv
// Peripheral bus address decoder top. Joins the window and RAM matchers,
// forms the target offset, runs the sequencer and registers the
// segment-cap flag. Assumes req is a single-cycle pulse.
module pbus_decode
    import pbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_acc,
    input  logic              bus_en,
    input  logic [EN_W-1:0]   per_en,
    input  logic              ram_lo_en,
    output logic [1:0]        ram_sel,
    output logic [WIN_N-1:0]  win_sel,
    output logic              ext_sel,
    output logic [OFF_W-1:0]  dev_off,
    output logic              rdy,
    output logic              acc_err,
    output logic              seg_cap
);

    logic [WIN_N-1:0] win_hit;
    logic             win_any;
    logic             lo_hit;
    logic             hi_hit;
    logic [TGT_W-1:0] hit_vec;
    logic [TGT_W-1:0] tgt_q;
    logic [OFF_W-1:0] off_d;
    logic             cap_d;

    pbus_win_match #(
        .P_ADDR_W (ADDR_W),
        .P_WIN_N  (WIN_N),
        .P_WIN_AW (WIN_AW),
        .P_EN_W   (EN_W)
    ) u_win (
        .addr    (addr),
        .bus_en  (bus_en),
        .per_en  (per_en),
        .win_hit (win_hit),
        .win_any (win_any)
    );

    pbus_ram_match #(
        .P_ADDR_W  (ADDR_W),
        .P_LO_AW   (LO_AW),
        .P_SEG_LSB (SEG_LSB)
    ) u_ram (
        .addr   (addr),
        .lo_en  (ram_lo_en),
        .lo_hit (lo_hit),
        .hi_hit (hi_hit)
    );

    // Target vector: bit 0 small RAM, bit 1 large RAM, then the windows
    always_comb begin
        hit_vec = {win_hit, hi_hit, lo_hit};
    end

    // Offset inside the hit target, zero when nothing is hit
    always_comb begin
        off_d = '0;
        if (hi_hit) begin
            off_d = addr[HI_AW-1:0];
        end else if (lo_hit) begin
            off_d = OFF_W'(addr[LO_AW-1:0]);
        end else if (win_any) begin
            off_d = OFF_W'(addr[WIN_AW-1:0]);
        end
    end

    pbus_seq #(
        .P_TGT_W  (TGT_W),
        .P_OFF_W  (OFF_W),
        .P_WAIT_N (WAIT_N)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .is_byte (byte_acc),
        .hit_vec (hit_vec),
        .win_any (win_any),
        .off_in  (off_d),
        .tgt_q   (tgt_q),
        .off_q   (dev_off),
        .rdy     (rdy),
        .flt     (acc_err),
        .pass    (ext_sel)
    );

    // Split the held target into the RAM and window selects
    always_comb begin
        ram_sel = tgt_q[1:0];
        win_sel = tgt_q[TGT_W-1:2];
    end

    // Segment cap is wanted when any of the leading (CAN) windows is live
    always_comb begin
        cap_d = bus_en && (|per_en[CAP_WINS-1:0]);
    end

    // Register the segment-cap flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_cap <= 1'b0;
        end else begin
            seg_cap <= cap_d;
        end
    end

endmodule

// File: rtl/pbus_decode_chk.sv
// Cycle-by-cycle properties of the decoder outputs, bound to the top.
// Assumes the default wait-state count fits in an 8-bit run counter.
module pbus_decode_chk
    import pbus_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       ram_sel,
    input logic [WIN_N-1:0] win_sel,
    input logic             ext_sel,
    input logic             rdy,
    input logic             acc_err,
    input logic             seg_cap,
    input logic             bus_en
);

    logic [7:0] win_run;

    // Count consecutive cycles a window select has been high before this one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_run <= '0;
        end else if (|win_sel) begin
            if (win_run != 8'hFF) begin
                win_run <= win_run + 1'b1;
            end
        end else begin
            win_run <= '0;
        end
    end

    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({win_sel, ram_sel, ext_sel}));

    // R6
    ram_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ram_sel) |-> rdy);

    // R7
    win_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && (|win_sel)) |-> (win_run == 8'(WAIT_N)));

    // R8
    err_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> ((win_sel == '0) && (ram_sel == '0) && !rdy));

    // R8
    err_then_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |=> (rdy && !acc_err));

    // R9
    ext_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel |=> !ext_sel);

    // R9
    ext_nordy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel |-> !rdy);

    // R6
    rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);

    // R11
    cap_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_cap |-> $past(bus_en));

endmodule

bind pbus_decode pbus_decode_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ram_sel (ram_sel),
    .win_sel (win_sel),
    .ext_sel (ext_sel),
    .rdy     (rdy),
    .acc_err (acc_err),
    .seg_cap (seg_cap),
    .bus_en  (bus_en)
);

// File: tb/pbus_decode_bench.sv
// Scoreboard bench: the driver queues the expected response of each
// request, and the monitor pops and compares it when the response appears.
module pbus_decode_bench;

    localparam int WAITS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [23:0] addr = '0;
    logic        byte_acc = 1'b0;
    logic        bus_en = 1'b0;
    logic [8:0]  per_en = '0;
    logic        ram_lo_en = 1'b0;
    logic [1:0]  ram_sel;
    logic [5:0]  win_sel;
    logic        ext_sel;
    logic [13:0] dev_off;
    logic        rdy;
    logic        acc_err;
    logic        seg_cap;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit err_seen = 0;
    bit done = 0;

    typedef struct {
        logic [7:0]  tgt;
        int          lat;
        bit          err;
        bit          ext;
        logic [13:0] off;
        int          start;
        string       rq;
    } exp_t;

    exp_t sb[$];

    int pg [6] = '{'hEF, 'hEE, 'hED, 'hEC, 'hE9, 'hE8};
    int enb[6] = '{0, 1, 4, 6, 7, 8};

    pbus_decode u_pbus_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .addr      (addr),
        .byte_acc  (byte_acc),
        .bus_en    (bus_en),
        .per_en    (per_en),
        .ram_lo_en (ram_lo_en),
        .ram_sel   (ram_sel),
        .win_sel   (win_sel),
        .ext_sel   (ext_sel),
        .dev_off   (dev_off),
        .rdy       (rdy),
        .acc_err   (acc_err),
        .seg_cap   (seg_cap)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Expected response from the requirement tables (R1..R4, R6..R9)
    function automatic exp_t model(input logic [23:0] a, input bit bt);
        exp_t e;
        e.tgt = '0; e.lat = 1; e.err = 0; e.ext = 1; e.off = '0;
        e.start = 0; e.rq = "R9";
        if (a[23:16] == 8'h09) begin
            e.tgt = 8'b10; e.off = a[13:0]; e.ext = 0; e.rq = "R2";
        end else if (ram_lo_en && a >= 24'h00E000 && a <= 24'h00E7FF) begin
            e.tgt = 8'b01; e.off = 14'(a - 24'h00E000); e.ext = 0; e.rq = "R1";
        end else begin
            for (int i = 0; i < 6; i++) begin
                if (a[23:8] == 16'(pg[i]) && bus_en && per_en[enb[i]]) begin
                    e.ext = 0;
                    if (bt) begin
                        e.err = 1; e.lat = 2; e.rq = "R8";
                    end else begin
                        e.tgt = 8'(1 << (2 + i)); e.off = 14'(a[7:0]);
                        e.lat = 1 + WAITS; e.rq = "R7";
                    end
                end
            end
        end
        return e;
    endfunction

    // Driver: issue one request and queue its expected response
    task automatic access(input logic [23:0] a, input bit bt, input string tag);
        exp_t e;
        @(negedge clk);
        e = model(a, bt);
        e.start = cyc;
        e.rq = {e.rq, "/", tag};
        sb.push_back(e);
        addr = a; byte_acc = bt; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Monitor: compare each response against the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (acc_err) err_seen = 1;
            if (rdy || ext_sel) begin
                if (sb.size() == 0) begin
                    chk(0, "R10 unexpected response", {30'd0, rdy, ext_sel}, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk((cyc - e.start) == e.lat, {e.rq, " latency"},
                        32'(cyc - e.start), 32'(e.lat));
                    chk(ext_sel == e.ext, {e.rq, " ext"}, 32'(ext_sel), 32'(e.ext));
                    chk({win_sel, ram_sel} == e.tgt, {e.rq, " select"},
                        32'({win_sel, ram_sel}), 32'(e.tgt));
                    chk(err_seen == e.err, {e.rq, " error pulse"},
                        32'(err_seen), 32'(e.err));
                    if (!e.ext && !e.err)
                        chk(dev_off == e.off, {e.rq, " offset"},
                            32'(dev_off), 32'(e.off));
                end
                err_seen = 0;
            end
        end
    end

    initial begin
        #(4 * 150000);
        chk(0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: outputs idle in reset
        chk({ram_sel, win_sel, ext_sel, dev_off, rdy, acc_err, seg_cap} == '0,
            "R12 reset outputs", 32'({ram_sel, win_sel, ext_sel, rdy, acc_err, seg_cap}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ram_sel, win_sel, ext_sel, rdy, acc_err, seg_cap} == '0,
            "R12 after reset", 32'({ram_sel, win_sel, ext_sel, rdy, acc_err, seg_cap}), 0);

        bus_en = 1'b1; per_en = 9'h1FF; ram_lo_en = 1'b1;
        // R1 small RAM edges
        access(24'h00E000, 0, "R1 low edge");
        access(24'h00E7FF, 1, "R1 high edge byte");
        access(24'h00DFFF, 0, "R1 below");
        ram_lo_en = 1'b0;
        access(24'h00E3A4, 0, "R1 disabled");
        ram_lo_en = 1'b1;
        // R2 large RAM mirrors
        access(24'h090000, 0, "R2 base");
        access(24'h093FFF, 1, "R2 top byte");
        access(24'h094000, 0, "R2 mirror");
        access(24'h09C123, 0, "R2 mirror high");
        access(24'h08FFFF, 0, "R2 below seg");
        access(24'h0A0000, 0, "R2 above seg");
        // R3 window edges and gaps
        for (int i = 0; i < 6; i++) begin
            access({8'h00, 8'(pg[i]), 8'h00}, 0, "R3 window first");
            access({8'h00, 8'(pg[i]), 8'hFF}, 0, "R3 window last");
        end
        access(24'h00EA40, 0, "R3 gap");
        access(24'h00EB40, 0, "R3 gap");
        access(24'h01EF00, 0, "R3 other segment");
        // R8 byte access refused on live windows
        for (int i = 0; i < 6; i++) access({8'h00, 8'(pg[i]), 8'h22}, 1, "R8 byte");
        // R10 request during wait states is dropped
        @(negedge clk);
        begin
            exp_t e;
            e = model(24'h00ED10, 0);
            e.start = cyc; e.rq = {e.rq, "/R10 first"};
            sb.push_back(e);
        end
        addr = 24'h00ED10; byte_acc = 0; req = 1'b1;
        @(negedge clk);
        addr = 24'h090010; req = 1'b1;
        @(negedge clk);
        addr = 24'h00E100;
        @(negedge clk);
        req = 1'b0;
        repeat (6) @(negedge clk);
        chk(sb.size() == 0, "R10 queue drained", 32'(sb.size()), 0);
        // R4 and R11: every enable combination
        for (int c = 0; c < 128; c++) begin
            @(negedge clk);
            bus_en = c[6];
            per_en = 9'b000101100;
            for (int i = 0; i < 6; i++) per_en[enb[i]] = c[i];
            @(negedge clk);
            @(negedge clk);
            chk(seg_cap == (c[6] && (c[0] || c[1])), "R11 seg cap",
                32'(seg_cap), 32'(c[6] && (c[0] || c[1])));
            for (int i = 0; i < 6; i++)
                access({8'h00, 8'(pg[i]), 8'h10}, 0, "R4 enable sweep");
        end
        // R4 byte access on a disabled window goes external, not error
        bus_en = 1'b0;
        access(24'h00EF02, 1, "R4 byte disabled");
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R9 all responses seen", 32'(sb.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule